// File: doc/BRIEF.md
# I2C Display-Transmitter Register Stub

This block is an I2C target that stands in for the control port of an HDMI/DVI transmitter. It answers only the few registers that host software touches while bringing up a display: an identification register, a system-control register and an interrupt-status register. With these, the host can detect the device and take over the downstream display data channel (DDC) so that it can read the monitor's EDID through the bypass. Every other register reads as zero, and writes to it are accepted and discarded.

The block oversamples SCL and SDA with its own clock through a short synchronizer. It finds START and STOP conditions and shifts bits in or out. It drives SDA only by pulling it low, through an open-drain enable. An 8-bit register pointer is loaded by the first data byte of each write transaction and steps forward after each data byte. Writing the system-control register runs a request/grant handshake. The handshake sets a request flag and a bypass flag, and both are brought out as ports to steer a DDC multiplexer.

Top module: `i2cDisplayStub`

## Requirements
- R1: The target acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal the TARGET_ADDR parameter, and leaves SDA released for any other address; it acknowledges every byte written after a matching address.
- R2: In a write transaction the first byte after the address byte loads the register pointer and changes no register state.
- R3: The pointer steps up by one after every data byte sent to the host and after every register byte written; a burst therefore walks consecutive registers.
- R4: Writing register 0x1A with bit 2 (request) set raises ddcRequest; if bit 1 (grant) is also set, ddcMode rises as well; with bit 2 set and bit 1 clear, ddcMode keeps its value.
- R5: Writing register 0x1A with bit 2 clear drops both ddcRequest and ddcMode, whatever the other bits hold.
- R6: Reading register 0x1A returns 0x06 while ddcRequest is high and 0x00 otherwise.
- R7: Reading register 0x1B always returns 0xB0.
- R8: Reading register 0x3D returns 0x04 (sink present, no event pending); any other register other than 0x1A and 0x1B, including the interrupt-enable register 0x3C, reads 0x00.
- R9: A write to any register other than 0x1A is acknowledged and leaves every read value and both flags unchanged.
- R10: Reset clears the pointer to 0x00, lowers ddcRequest and ddcMode, cancels a pending pointer load and releases SDA.
- R11: A repeated START followed by a matching write address makes the next byte a pointer load again.
- R12: A host NACK after a read byte ends the read: SDA is released and a following read starts at the register after the last one sent.
- R13: The target changes SDA only while SCL is low; it never starts pulling SDA low while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | I2C clock line as seen at the pad |
| sdaIn | input | 1 | I2C data line as seen at the pad |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| ddcMode | output | 1 | DDC bypass granted: host owns the downstream DDC bus |
| ddcRequest | output | 1 | DDC bus request flag from the last control write |

## Verification
Four properties are checked on every clock: the bypass flag is never high without the request flag, SDA is pulled low only from a low SCL, the request flag moves only after a written data byte, and the pointer moves only after a written or sent data byte. The values of the canned registers, the pointer-load rule across repeated STARTs, pointer stepping within bursts, address filtering, and the NACK and reset behaviour are visible only through bus transactions. The bench's scenarios therefore cover them.

// File: rtl/i2cStubPkg.sv
package i2cStubPkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;

  // register locations the host software depends on
  localparam logic [DATA_W-1:0] REG_SYS_CTRL  = 8'h1A;
  localparam logic [DATA_W-1:0] REG_DEVICE_ID = 8'h1B;
  localparam logic [DATA_W-1:0] REG_IRQ_STAT  = 8'h3D;

  // canned read values
  localparam logic [DATA_W-1:0] DEVICE_ID_VAL = 8'hB0;
  localparam logic [DATA_W-1:0] PLUGGED_VAL   = 8'h04;
  localparam logic [DATA_W-1:0] HANDSHAKE_VAL = 8'h06;

  // system-control bit positions
  localparam int REQ_BIT   = 2;
  localparam int GRANT_BIT = 1;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic busStart;  // START or repeated START seen
    logic armPtr;    // matching write address: next byte is a pointer
    logic wrByte;    // a data byte has been received
    logic rdLoad;    // a read byte is being loaded for transmit
  } stubStrobeT;

endpackage

// File: rtl/i2cStubLineSync.sv
module i2cStubLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic          sclPrev;
  logic          sdaPrev;

  // idle bus is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclPipe[LAST];
      sdaPrev <= sdaPipe[LAST];
    end
  end

  assign sclLvl    = sclPipe[LAST];
  assign sdaLvl    = sdaPipe[LAST];
  assign sclRise   = !sclPrev && sclLvl;
  assign sclFall   = sclPrev && !sclLvl;
  assign startCond = sclPrev && sclLvl && sdaPrev && !sdaLvl;
  assign stopCond  = sclPrev && sclLvl && !sdaPrev && sdaLvl;

endmodule

// File: rtl/i2cStubCtrl.sv
module i2cStubCtrl
  import i2cStubPkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startCond,
  input  logic              stopCond,
  input  logic [DATA_W-1:0] readData,
  output stubStrobeT        strobe,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdaPullLow
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } busStateT;

  busStateT          state;
  logic [2:0]        bitCnt;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic              fullByte;
  logic              addrHit;
  logic              rwBit;
  logic              hostAck;
  logic              pullLow;

  logic lastBitRise;
  logic addrMatch;

  assign lastBitRise = sclRise && (bitCnt == 3'd7);
  assign addrMatch   = (rxShift[ADDR_W-1:0] == TARGET_ADDR);
  assign rxByte      = {rxShift[DATA_W-2:0], sdaLvl};
  assign sdaPullLow  = pullLow;

  always_comb begin
    strobe          = '0;
    strobe.busStart = startCond;
    strobe.armPtr   = (state == ST_ADDR) && lastBitRise && addrMatch && !sdaLvl;
    strobe.wrByte   = (state == ST_WDATA) && lastBitRise;
    strobe.rdLoad   = sclFall && (((state == ST_ADDR_ACK) && rwBit) ||
                                  ((state == ST_RDATA_ACK) && hostAck));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      fullByte <= 1'b0;
      addrHit  <= 1'b0;
      rwBit    <= 1'b0;
      hostAck  <= 1'b0;
      pullLow  <= 1'b0;
    end else if (startCond) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      fullByte <= 1'b0;
      pullLow  <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      fullByte <= 1'b0;
      pullLow  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            rxShift <= rxByte;
            bitCnt  <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              fullByte <= 1'b1;
              if (state == ST_ADDR) begin
                addrHit <= addrMatch;
                rwBit   <= sdaLvl;
              end
            end
          end else if (sclFall && fullByte) begin
            fullByte <= 1'b0;
            bitCnt   <= '0;
            if (state == ST_WDATA) begin
              state   <= ST_WDATA_ACK;
              pullLow <= 1'b1;
            end else if (addrHit) begin
              state   <= ST_ADDR_ACK;
              pullLow <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (rwBit) begin
              state   <= ST_RDATA;
              txShift <= readData;
              pullLow <= !readData[DATA_W-1];
            end else begin
              state   <= ST_WDATA;
              pullLow <= 1'b0;
            end
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) begin
            state   <= ST_WDATA;
            pullLow <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              state   <= ST_RDATA_ACK;
              bitCnt  <= '0;
              pullLow <= 1'b0;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txShift <= {txShift[DATA_W-2:0], 1'b0};
              pullLow <= !txShift[DATA_W-2];
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclRise) begin
            hostAck <= !sdaLvl;
          end else if (sclFall) begin
            if (hostAck) begin
              state   <= ST_RDATA;
              txShift <= readData;
              pullLow <= !readData[DATA_W-1];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cStubRegs.sv
module i2cStubRegs
  import i2cStubPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stubStrobeT        strobe,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] regPtr,
  output logic              ddcMode,
  output logic              ddcRequest
);

  logic ptrPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr     <= '0;
      ptrPending <= 1'b0;
      ddcMode    <= 1'b0;
      ddcRequest <= 1'b0;
    end else begin
      if (strobe.busStart) ptrPending <= 1'b0;
      if (strobe.armPtr)   ptrPending <= 1'b1;
      if (strobe.wrByte) begin
        if (ptrPending) begin
          regPtr     <= rxByte;
          ptrPending <= 1'b0;
        end else begin
          if (regPtr == REG_SYS_CTRL) begin
            if (rxByte[REQ_BIT]) begin
              ddcRequest <= 1'b1;
              if (rxByte[GRANT_BIT]) ddcMode <= 1'b1;
            end else begin
              ddcRequest <= 1'b0;
              ddcMode    <= 1'b0;
            end
          end
          regPtr <= regPtr + 1'b1;
        end
      end
      if (strobe.rdLoad) regPtr <= regPtr + 1'b1;
    end
  end

  always_comb begin
    unique case (regPtr)
      REG_SYS_CTRL:  readData = ddcRequest ? HANDSHAKE_VAL : '0;
      REG_DEVICE_ID: readData = DEVICE_ID_VAL;
      REG_IRQ_STAT:  readData = PLUGGED_VAL;
      default:       readData = '0;
    endcase
  end

endmodule

// File: rtl/i2cDisplayStub.sv
module i2cDisplayStub
  import i2cStubPkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h39,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  output logic ddcMode,
  output logic ddcRequest
);

  logic              sclLvl;
  logic              sdaLvl;
  logic              sclRise;
  logic              sclFall;
  logic              startCond;
  logic              stopCond;
  stubStrobeT        strobe;
  logic [DATA_W-1:0] rxByte;
  logic [DATA_W-1:0] readData;
  logic [DATA_W-1:0] regPtr;

  i2cStubLineSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclLvl    (sclLvl),
    .sdaLvl    (sdaLvl),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startCond (startCond),
    .stopCond  (stopCond)
  );

  i2cStubCtrl #(.TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sdaLvl     (sdaLvl),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .startCond  (startCond),
    .stopCond   (stopCond),
    .readData   (readData),
    .strobe     (strobe),
    .rxByte     (rxByte),
    .sdaPullLow (sdaPullLow)
  );

  i2cStubRegs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxByte     (rxByte),
    .readData   (readData),
    .regPtr     (regPtr),
    .ddcMode    (ddcMode),
    .ddcRequest (ddcRequest)
  );

endmodule

// File: rtl/i2cDisplayStubChk.sv
module i2cDisplayStubChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclLvl,
  input logic       sdaPullLow,
  input logic       ddcMode,
  input logic       ddcRequest,
  input logic       wrByte,
  input logic       rdLoad,
  input logic [7:0] regPtr
);

  assert_bypass_needs_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    ddcMode |-> ddcRequest);

  assert_pull_from_low_scl_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclLvl);

  assert_req_moves_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ddcRequest) |-> $past(wrByte));

  assert_ptr_moves_on_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regPtr) |-> $past(wrByte || rdLoad));

endmodule

bind i2cDisplayStub i2cDisplayStubChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclLvl     (sclLvl),
  .sdaPullLow (sdaPullLow),
  .ddcMode    (ddcMode),
  .ddcRequest (ddcRequest),
  .wrByte     (strobe.wrByte),
  .rdLoad     (strobe.rdLoad),
  .regPtr     (regPtr)
);

// File: tb/test_i2cDisplayStub.sv
`timescale 1ns/1ps
module test_i2cDisplayStub;

  localparam int  Q     = 10;      // clock cycles per quarter bit
  localparam logic [7:0] ADDR_W = 8'h72;  // 0x39 write
  localparam logic [7:0] ADDR_R = 8'h73;  // 0x39 read

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow, ddcMode, ddcRequest;
  logic sdaBus;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign sdaBus = sdaM & ~sdaPullLow;

  i2cDisplayStub i_i2cDisplayStub (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaPullLow (sdaPullLow),
    .ddcMode    (ddcMode),
    .ddcRequest (ddcRequest)
  );

  typedef struct packed {
    logic       doWr;
    logic [7:0] wAddr;
    logic [7:0] wData;
    logic [7:0] rAddr;
    logic [7:0] expRd;
    logic       expReq;
    logic       expMode;
    logic [3:0] reqNo;
  } vecT;

  localparam vecT VEC [0:13] = '{
    '{1'b0, 8'h00, 8'h00, 8'h1B, 8'hB0, 1'b0, 1'b0, 4'd7},  // R7 id
    '{1'b0, 8'h00, 8'h00, 8'h3D, 8'h04, 1'b0, 1'b0, 4'd8},  // R8 status
    '{1'b0, 8'h00, 8'h00, 8'h3C, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 enable reads 0
    '{1'b0, 8'h00, 8'h00, 8'h1A, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 idle
    '{1'b1, 8'h1A, 8'h04, 8'h1A, 8'h06, 1'b1, 1'b0, 4'd4},  // R4 request only
    '{1'b1, 8'h1A, 8'h06, 8'h1A, 8'h06, 1'b1, 1'b1, 4'd4},  // R4 request+grant
    '{1'b1, 8'h1A, 8'h04, 8'h1A, 8'h06, 1'b1, 1'b1, 4'd4},  // R4 mode held
    '{1'b1, 8'h1A, 8'h00, 8'h1A, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 release
    '{1'b1, 8'h1A, 8'h06, 8'h1B, 8'hB0, 1'b1, 1'b1, 4'd4},  // R4 again
    '{1'b1, 8'h1A, 8'h02, 8'h1A, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 grant w/o request
    '{1'b1, 8'h1B, 8'hFF, 8'h1B, 8'hB0, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 8'h3D, 8'h00, 8'h3D, 8'h04, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 8'h3C, 8'hFF, 8'h3C, 8'h00, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8}   // R8 other
  };

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b0; qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b1; qwait();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; qwait();
    sclM = 1'b1; qwait(); qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    b = sdaBus; qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    getBit(a);
    acked = !a;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    logic k0, k1, k2;
    busStart();
    sendByte(ADDR_W, k0);
    sendByte(a, k1);
    sendByte(d, k2);
    busStop();
    check("R1 write acks", {5'd0, k0, k1, k2}, 8'h07);
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    logic k0, k1, k2;
    busStart();
    sendByte(ADDR_W, k0);
    sendByte(a, k1);
    busStart();
    sendByte(ADDR_R, k2);
    recvByte(d, 1'b0);
    busStop();
    check("R1 read acks", {5'd0, k0, k1, k2}, 8'h07);
  endtask

  initial begin
    logic [7:0] rd;
    logic       k;
    logic [7:0] burst [0:27];

    repeat (5) @(negedge clk);
    // R10: state after power-on reset
    check("R10 sdaPullLow at reset", {7'd0, sdaPullLow}, 8'h00);
    check("R10 ddcRequest at reset", {7'd0, ddcRequest}, 8'h00);
    check("R10 ddcMode at reset", {7'd0, ddcMode}, 8'h00);
    rstN = 1'b1;
    qwait();

    // vector table
    for (int i = 0; i < 14; i++) begin
      if (VEC[i].doWr) writeReg(VEC[i].wAddr, VEC[i].wData);
      readReg(VEC[i].rAddr, rd);
      check($sformatf("R%0d vec%0d read", VEC[i].reqNo, i), rd, VEC[i].expRd);
      check($sformatf("R%0d vec%0d ddcRequest", VEC[i].reqNo, i), {7'd0, ddcRequest}, {7'd0, VEC[i].expReq});
      check($sformatf("R%0d vec%0d ddcMode", VEC[i].reqNo, i), {7'd0, ddcMode}, {7'd0, VEC[i].expMode});
    end

    // R2: first byte after write address is a pointer, never data (0x04 would raise request at 0x1A)
    writeReg(8'h1B, 8'h00);  // leaves pointer at 0x1C
    busStart(); sendByte(ADDR_W, k); sendByte(8'h1A, k); busStop();
    busStart(); sendByte(ADDR_W, k); sendByte(8'h04, k); busStop();
    check("R2 pointer byte not written", {7'd0, ddcRequest}, 8'h00);

    // R11: repeated START makes the next byte a pointer again
    busStart(); sendByte(ADDR_W, k); sendByte(8'h1A, k);
    busStart(); sendByte(ADDR_W, k); sendByte(8'h3D, k); busStop();
    check("R11 restart byte not written to 0x1A", {7'd0, ddcRequest}, 8'h00);
    busStart(); sendByte(ADDR_R, k); recvByte(rd, 1'b0); busStop();
    check("R11 pointer reloaded to 0x3D", rd, 8'h04);

    // R3: written burst walks 0x19 -> 0x1A
    busStart(); sendByte(ADDR_W, k); sendByte(8'h19, k);
    sendByte(8'hAA, k); sendByte(8'h06, k); busStop();
    check("R3 write burst reached 0x1A", {6'd0, ddcRequest, ddcMode}, 8'h03);

    // R3: read burst 0x1A, 0x1B
    busStart(); sendByte(ADDR_W, k); sendByte(8'h1A, k);
    busStart(); sendByte(ADDR_R, k);
    recvByte(rd, 1'b1);
    check("R3 burst byte0", rd, 8'h06);
    recvByte(rd, 1'b0);
    check("R3 burst byte1", rd, 8'hB0);
    busStop();

    // R12: NACK ends the read, next read continues after it
    busStart(); sendByte(ADDR_W, k); sendByte(8'h1A, k);
    busStart(); sendByte(ADDR_R, k); recvByte(rd, 1'b0);
    check("R12 nacked byte", rd, 8'h06);
    check("R12 SDA released after NACK", {7'd0, sdaPullLow}, 8'h00);
    busStop();
    busStart(); sendByte(ADDR_R, k); recvByte(rd, 1'b0); busStop();
    check("R12 resume after nacked byte", rd, 8'hB0);

    // R1: wrong address gets no acknowledge
    busStart(); sendByte(8'h74, k); busStop();
    check("R1 foreign address not acked", {7'd0, k}, 8'h00);
    busStart(); sendByte(8'hE4, k); busStop();
    check("R1 foreign address not acked", {7'd0, k}, 8'h00);

    // R13: ACK driven only after SCL falls
    busStart();
    for (int i = 7; i >= 1; i--) sendBit(ADDR_W[i]);
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    check("R13 no pull while SCL high", {7'd0, sdaPullLow}, 8'h00);
    qwait();
    sclM = 1'b0; qwait();
    check("R13 ACK pull after SCL fall", {7'd0, sdaPullLow}, 8'h01);
    getBit(k);
    busStop();

    // R10: reset mid-run after bypass was granted
    check("R10 bypass active before reset", {7'd0, ddcMode}, 8'h01);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 ddcMode cleared", {7'd0, ddcMode}, 8'h00);
    check("R10 ddcRequest cleared", {7'd0, ddcRequest}, 8'h00);
    rstN = 1'b1;
    qwait();
    busStart(); sendByte(ADDR_R, k);
    for (int i = 0; i < 28; i++) begin
      recvByte(rd, i != 27);
      burst[i] = rd;
    end
    busStop();
    check("R10 pointer from 0: 0x1A reads 0", burst[26], 8'h00);
    check("R10 pointer from 0: 0x1B reads id", burst[27], 8'hB0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule